// File: doc/BRIEF.md
# Address Decoder with Alignment and Operand-Fetch Sequencing

This block sits between a processor's memory request port and six memory-mapped devices on a 24-bit address bus. It accepts one request at a time through a valid/ready handshake. The request carries an address, an access size (byte, half-word or word), a direction and a 4-bit access status code. Before any device is touched, the block checks alignment and looks the address up in a fixed region map. It then either raises a one-hot device select for a single access or answers at once with a classified bus error. Alignment faults, accesses to unpopulated space and writes to the read-only region are each reported with their own error kind, together with the faulting address.

Operand fetches are the exception to the alignment rule. A read whose access code is the operand-fetch code skips the alignment check. The block turns it into a run of single-byte device reads at consecutive addresses and packs the bytes little-endian into the response word. The device is chosen once, from the starting address. A device error on any byte aborts the run and is reported.

The devices answer in the same cycle as the strobe: the select and strobe are held for one cycle per access, and the read data and error flag are sampled at the end of that cycle.

Top module: `bus_decoder_top`

## Requirements
- R1: The device select is one-hot while the strobe is high and all zero otherwise. The bits are: bit 0 for the read-only program store 0x000000–0x01FFFF, bit 1 for the serial controller 0x200000–0x20003F, bit 2 for the pointer position 0x400000–0x400003, bit 3 for the display base register 0x500000–0x500001, bit 4 for the battery-backed store 0x600000–0x601FFF, and bit 5 for main memory 0x700000–0x7FFFFF.
- R2: An address outside every region, including the unpopulated window 0x300000–0x3000FF, returns an error with kind 2'b10 (no device) and the request address as fault address, and no strobe is issued.
- R3: A half-word access (size 2'b01) at an odd address returns an error with kind 2'b01 (alignment), and no strobe is issued.
- R4: A word access (size 2'b10) whose address is not a multiple of 4 returns an alignment error, as does any request with the reserved size code 2'b11. Alignment is checked before the region lookup, so a misaligned write to the read-only region reports alignment.
- R5: Byte accesses (size 2'b00) are never rejected for alignment.
- R6: A write to the read-only region returns an error with kind 2'b11 (read-only), and no strobe is issued.
- R7: A read with access code 4'd9 (operand fetch) issues N byte strobes (N = 1, 2 or 4 for sizes 00, 01, 10) at addr, addr+1, and so on, each with size 2'b00 and code 4'd9. Byte n lands in response bits 8n+7:8n, with no alignment check, and the select stays the one decoded from the starting address.
- R8: If the device flags an error on a strobe, the access ends at once with kind 2'b10 and that strobe's address as fault address. No further bytes are fetched.
- R9: Every write strobe carries access code 4'd10 and the request's write data and size. An ordinary read passes the request's own access code to the device.
- R10: A decode-stage error responds in the cycle after acceptance. A single access responds 2 cycles after acceptance. An N-byte operand fetch responds N+1 cycles after acceptance, or k+1 cycles if it aborts on strobe k. Ready is low while strobes are in progress.
- R11: Reset (synchronous, active high) leaves ready high and the strobe, select and response-valid low, including when it is applied in the middle of an operand fetch.
- R12: A response has err = 0 and kind 2'b00 exactly when it succeeds. Error responses and write responses return data 0, and a successful read returns the device data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 24 | Byte address |
| req_size | input | 2 | 00 byte, 01 half, 10 word, 11 reserved |
| req_write | input | 1 | 1 = write |
| req_code | input | 4 | Access status code |
| req_wdata | input | 32 | Write data |
| dev_stb | output | 1 | Device access this cycle |
| dev_sel | output | 6 | One-hot region select |
| dev_addr | output | 24 | Device byte address |
| dev_size | output | 2 | Device access size |
| dev_write | output | 1 | Device write |
| dev_code | output | 4 | Access status code to device |
| dev_wdata | output | 32 | Device write data |
| dev_rdata | input | 32 | Device read data, same cycle |
| dev_err | input | 1 | Device error, same cycle |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response is an error |
| rsp_kind | output | 2 | 00 none, 01 alignment, 10 no device, 11 read-only |
| rsp_fault | output | 24 | Faulting address on error |
| rsp_data | output | 32 | Read data |

## Verification
Every result has a fixed due cycle counted from the accepting clock edge. A decode-stage error is due in cycle 1, a single device access in cycle 2, and an N-byte operand fetch in cycle N+1, or k+1 when strobe k reports an error. The bench counts the falling edges after the accepting edge until it sees the response pulse, and compares that count with the latency stored in each vector. It also logs every strobe, with its address, code, select and ready state, on falling edges. This confirms that no strobe appears for rejected requests and that fetch bytes go out at successive cycles and addresses.

// File: rtl/busdec_pkg.sv
package busdec_pkg;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 32;
    localparam int NREG   = 6;
    localparam int CODE_W = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        EK_NONE   = 2'd0,
        EK_ALIGN  = 2'd1,
        EK_NODEV  = 2'd2,
        EK_RDONLY = 2'd3
    } errk_e;

    // Access status codes; only OPND and WRITE change how the block behaves.
    typedef enum logic [3:0] {
        AC_XLAT_MOVE = 4'd0,
        AC_CP_WRITE  = 4'd1,
        AC_VEC_ACK   = 4'd2,
        AC_CP_READ   = 4'd3,
        AC_HALT_ACK  = 4'd4,
        AC_CP_BCAST  = 4'd5,
        AC_CP_STATUS = 4'd6,
        AC_LOCK_RD   = 4'd7,
        AC_ADDR_RD   = 4'd8,
        AC_OPND      = 4'd9,
        AC_WRITE     = 4'd10,
        AC_INT_ACK   = 4'd11,
        AC_IF_BRANCH = 4'd12,
        AC_PREFETCH  = 4'd13,
        AC_IFETCH    = 4'd14,
        AC_IDLE      = 4'd15
    } acode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACC  = 1'b1
    } state_e;

    // Region table: base address and log2 of the span (spans are aligned powers of two).
    localparam logic [31:0] REG_BASE [NREG] = '{
        32'h000000, 32'h200000, 32'h400000, 32'h500000, 32'h600000, 32'h700000
    };
    localparam int REG_LOG2 [NREG] = '{17, 6, 2, 1, 13, 20};
    localparam int RO_REGION = 0;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [1:0]        size;
        logic              write;
        logic [CODE_W-1:0] code;
        logic              op;
        logic [DATA_W-1:0] wdata;
    } cur_t;

    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (size_e'(sz))
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/busdec_region.sv
module busdec_region
    import busdec_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NR = NREG
) (
    input  logic [AW-1:0] addr,
    output logic [NR-1:0] sel,
    output logic          hit,
    output logic          ro
);
    for (genvar g = 0; g < NR; g++) begin : g_reg
        localparam int L = REG_LOG2[g];
        localparam logic [31:0] B = REG_BASE[g];
        assign sel[g] = (addr[AW-1:L] == B[AW-1:L]);
    end

    assign hit = |sel;
    assign ro  = sel[RO_REGION];
endmodule

// File: rtl/busdec_align.sv
module busdec_align
    import busdec_pkg::*;
(
    input  logic [1:0] addr_lo,
    input  logic [1:0] size,
    output logic       mis
);
    always_comb begin
        case (size_e'(size))
            SZ_BYTE: mis = 1'b0;
            SZ_HALF: mis = addr_lo[0];
            SZ_WORD: mis = |addr_lo;
            default: mis = 1'b1;
        endcase
    end
endmodule

// File: rtl/busdec_opseq.sv
module busdec_opseq
    import busdec_pkg::*;
#(
    parameter int DW = DATA_W,
    localparam int LANES = DW / 8,
    localparam int IW = $clog2(LANES),
    localparam int NW = IW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [NW-1:0] nbytes,
    input  logic          step,
    input  logic [7:0]    byte_in,
    output logic          last,
    output logic [DW-1:0] data_next
);
    logic [NW-1:0] cnt, total;
    logic [DW-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            total <= '0;
            acc   <= '0;
        end else if (start) begin
            cnt   <= '0;
            total <= nbytes;
            acc   <= '0;
        end else if (step) begin
            acc <= data_next;
            cnt <= cnt + NW'(1);
        end
    end

    always_comb begin
        data_next = acc;
        data_next[cnt[IW-1:0]*8 +: 8] = byte_in;
    end

    assign last = (cnt + NW'(1) == total);

    // R7: never step past the requested byte count
    assert_step_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        step |-> (cnt < total));
endmodule

// File: rtl/bus_decoder_top.sv
module bus_decoder_top
    import busdec_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NR = NREG,
    parameter int CW = CODE_W,
    localparam int NW = $clog2(DW / 8) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic          req_write,
    input  logic [CW-1:0] req_code,
    input  logic [DW-1:0] req_wdata,
    output logic          dev_stb,
    output logic [NR-1:0] dev_sel,
    output logic [AW-1:0] dev_addr,
    output logic [1:0]    dev_size,
    output logic          dev_write,
    output logic [CW-1:0] dev_code,
    output logic [DW-1:0] dev_wdata,
    input  logic [DW-1:0] dev_rdata,
    input  logic          dev_err,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic [1:0]    rsp_kind,
    output logic [AW-1:0] rsp_fault,
    output logic [DW-1:0] rsp_data
);
    state_e        state;
    logic [AW-1:0] cur_addr;
    logic [1:0]    cur_size;
    logic          cur_write, cur_op;
    logic [CW-1:0] cur_code;
    logic [DW-1:0] cur_wdata;
    logic [NR-1:0] cur_sel;

    logic [NR-1:0] sel_in;
    logic          hit, ro, mis, opf, accept;
    errk_e         chk_kind;
    logic          seq_start, seq_step, seq_last;
    logic [DW-1:0] seq_data;

    busdec_region #(.AW(AW), .NR(NR)) u_region (
        .addr(req_addr), .sel(sel_in), .hit(hit), .ro(ro)
    );

    busdec_align u_align (
        .addr_lo(req_addr[1:0]), .size(req_size), .mis(mis)
    );

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign opf       = !req_write && (req_code == CW'(AC_OPND)) && (req_size != 2'(SZ_RSVD));

    // Alignment is judged first, then presence, then write permission.
    always_comb begin
        if (!opf && mis)          chk_kind = EK_ALIGN;
        else if (!hit)            chk_kind = EK_NODEV;
        else if (req_write && ro) chk_kind = EK_RDONLY;
        else                      chk_kind = EK_NONE;
    end

    assign seq_start = accept && opf && (chk_kind == EK_NONE);
    assign seq_step  = dev_stb && cur_op && !dev_err;

    busdec_opseq #(.DW(DW)) u_seq (
        .clk(clk), .rst(rst), .start(seq_start),
        .nbytes(NW'(size_bytes(req_size))), .step(seq_step),
        .byte_in(dev_rdata[7:0]), .last(seq_last), .data_next(seq_data)
    );

    assign dev_stb   = (state == ST_ACC);
    assign dev_sel   = dev_stb ? cur_sel : '0;
    assign dev_addr  = cur_addr;
    assign dev_size  = cur_op ? 2'(SZ_BYTE) : cur_size;
    assign dev_write = dev_stb && cur_write;
    assign dev_wdata = cur_wdata;
    assign dev_code  = cur_op ? CW'(AC_OPND) : (cur_write ? CW'(AC_WRITE) : cur_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_addr  <= '0;
            cur_size  <= '0;
            cur_write <= 1'b0;
            cur_op    <= 1'b0;
            cur_code  <= '0;
            cur_wdata <= '0;
            cur_sel   <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_kind  <= 2'(EK_NONE);
            rsp_fault <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cur_addr  <= req_addr;
                        cur_size  <= req_size;
                        cur_write <= req_write;
                        cur_op    <= opf;
                        cur_code  <= req_code;
                        cur_wdata <= req_wdata;
                        cur_sel   <= sel_in;
                        if (chk_kind != EK_NONE) begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b1;
                            rsp_kind  <= 2'(chk_kind);
                            rsp_fault <= req_addr;
                            rsp_data  <= '0;
                        end else begin
                            state <= ST_ACC;
                        end
                    end
                end
                ST_ACC: begin
                    if (dev_err) begin
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b1;
                        rsp_kind  <= 2'(EK_NODEV);
                        rsp_fault <= cur_addr;
                        rsp_data  <= '0;
                        state     <= ST_IDLE;
                    end else if (cur_op && !seq_last) begin
                        cur_addr <= cur_addr + AW'(1);
                    end else begin
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b0;
                        rsp_kind  <= 2'(EK_NONE);
                        rsp_fault <= '0;
                        rsp_data  <= cur_op ? seq_data : (cur_write ? '0 : dev_rdata);
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: exactly one region selected during a strobe, none otherwise
    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        dev_stb |-> $onehot(dev_sel));
    assert_sel_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !dev_stb |-> (dev_sel == '0));
    // R6: the read-only region never sees a write strobe
    assert_rom_unwritten_R6: assert property (@(posedge clk) disable iff (rst)
        dev_write |-> !dev_sel[RO_REGION]);
    // R3: an alignment error is never preceded by a device strobe
    assert_align_no_access_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == 2'(EK_ALIGN)) |-> !$past(dev_stb));
    // R7: back-to-back fetch strobes walk upward one byte at a time
    assert_fetch_walk_R7: assert property (@(posedge clk) disable iff (rst)
        (dev_stb && $past(dev_stb) && dev_code == CW'(AC_OPND)) |-> (dev_addr == $past(dev_addr) + AW'(1)));
    // R9: write strobes always carry the write code
    assert_write_code_R9: assert property (@(posedge clk) disable iff (rst)
        dev_write |-> (dev_code == CW'(AC_WRITE)));
    // R10: no new request is taken while strobes run
    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (rst)
        dev_stb |-> !req_ready);
    // R12: the error flag and the error kind agree
    assert_err_kind_R12: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_err == (rsp_kind != 2'(EK_NONE))));
endmodule

// File: tb/sim_bus_decoder_top.sv
module sim_bus_decoder_top;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst, req_valid, req_ready, req_write;
    logic [23:0] req_addr;
    logic [1:0]  req_size;
    logic [3:0]  req_code;
    logic [31:0] req_wdata;
    logic        dev_stb, dev_write, dev_err;
    logic [5:0]  dev_sel;
    logic [23:0] dev_addr;
    logic [1:0]  dev_size;
    logic [3:0]  dev_code;
    logic [31:0] dev_wdata, dev_rdata;
    logic        rsp_valid, rsp_err;
    logic [1:0]  rsp_kind;
    logic [23:0] rsp_fault;
    logic [31:0] rsp_data;

    bus_decoder_top u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_code(req_code), .req_wdata(req_wdata),
        .dev_stb(dev_stb), .dev_sel(dev_sel), .dev_addr(dev_addr), .dev_size(dev_size),
        .dev_write(dev_write), .dev_code(dev_code), .dev_wdata(dev_wdata),
        .dev_rdata(dev_rdata), .dev_err(dev_err),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_kind(rsp_kind),
        .rsp_fault(rsp_fault), .rsp_data(rsp_data)
    );

    // Bench's own view of the region map (from R1)
    localparam logic [23:0] T_LO [6] = '{24'h000000, 24'h200000, 24'h400000, 24'h500000, 24'h600000, 24'h700000};
    localparam logic [23:0] T_HI [6] = '{24'h01FFFF, 24'h20003F, 24'h400003, 24'h500001, 24'h601FFF, 24'h7FFFFF};

    function automatic logic [7:0] mbyte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    function automatic logic [31:0] pack_le(input logic [23:0] a, input int n);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) r[8*i +: 8] = mbyte(a + 24'(i));
        return r;
    endfunction

    function automatic int nbytes_of(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    // Byte-addressable responders: each flags an error outside its own span.
    always_comb begin
        dev_rdata = '0;
        dev_err   = 1'b0;
        if (dev_stb) begin
            dev_err = 1'b1;
            for (int k = 0; k < 6; k++)
                if (dev_sel[k] && dev_addr >= T_LO[k] && dev_addr <= T_HI[k]) dev_err = 1'b0;
            if (!dev_err && !dev_write) dev_rdata = pack_le(dev_addr, nbytes_of(dev_size));
        end
    end

    // Strobe monitor
    int          nstb;
    logic [23:0] s_addr [8];
    logic [3:0]  s_code [8];
    logic [1:0]  s_size [8];
    logic [5:0]  s_sel;
    logic        rdy_bad;
    logic [31:0] last_wd;
    always @(negedge clk) begin
        if (dev_stb) begin
            if (nstb < 8) begin
                s_addr[nstb] <= dev_addr;
                s_code[nstb] <= dev_code;
                s_size[nstb] <= dev_size;
            end
            if (nstb == 0) s_sel <= dev_sel;
            if (req_ready) rdy_bad <= 1'b1;
            if (dev_write) last_wd <= dev_wdata;
            nstb <= nstb + 1;
        end
    end

    int checks = 0;
    int errors = 0;

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [23:0] a;
        logic [1:0]  sz;
        logic        wr;
        logic [3:0]  code;
        logic [1:0]  kind;
        logic [23:0] fault;
        logic [3:0]  lat;
        logic [3:0]  nst;
        logic [5:0]  sel;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VT [NV] = '{
        '{24'h000010, 2'd2, 1'b0, 4'd8,  2'd0, 24'h000000, 4'd2, 4'd1, 6'h01},
        '{24'h200004, 2'd0, 1'b0, 4'd14, 2'd0, 24'h000000, 4'd2, 4'd1, 6'h02},
        '{24'h400002, 2'd1, 1'b0, 4'd8,  2'd0, 24'h000000, 4'd2, 4'd1, 6'h04},
        '{24'h500001, 2'd0, 1'b0, 4'd8,  2'd0, 24'h000000, 4'd2, 4'd1, 6'h08},
        '{24'h601FFC, 2'd2, 1'b0, 4'd8,  2'd0, 24'h000000, 4'd2, 4'd1, 6'h10},
        '{24'h7FFFFE, 2'd1, 1'b0, 4'd8,  2'd0, 24'h000000, 4'd2, 4'd1, 6'h20},
        '{24'h700001, 2'd1, 1'b1, 4'd10, 2'd1, 24'h700001, 4'd1, 4'd0, 6'h00},
        '{24'h700002, 2'd1, 1'b1, 4'd10, 2'd0, 24'h000000, 4'd2, 4'd1, 6'h20},
        '{24'h700001, 2'd2, 1'b1, 4'd10, 2'd1, 24'h700001, 4'd1, 4'd0, 6'h00},
        '{24'h700002, 2'd2, 1'b1, 4'd10, 2'd1, 24'h700002, 4'd1, 4'd0, 6'h00},
        '{24'h700003, 2'd2, 1'b1, 4'd10, 2'd1, 24'h700003, 4'd1, 4'd0, 6'h00},
        '{24'h700004, 2'd2, 1'b1, 4'd10, 2'd0, 24'h000000, 4'd2, 4'd1, 6'h20},
        '{24'h700003, 2'd0, 1'b1, 4'd10, 2'd0, 24'h000000, 4'd2, 4'd1, 6'h20},
        '{24'h300010, 2'd0, 1'b0, 4'd8,  2'd2, 24'h300010, 4'd1, 4'd0, 6'h00},
        '{24'h200040, 2'd0, 1'b0, 4'd8,  2'd2, 24'h200040, 4'd1, 4'd0, 6'h00},
        '{24'h000100, 2'd0, 1'b1, 4'd10, 2'd3, 24'h000100, 4'd1, 4'd0, 6'h00},
        '{24'h000101, 2'd1, 1'b0, 4'd9,  2'd0, 24'h000000, 4'd3, 4'd2, 6'h01},
        '{24'h700003, 2'd2, 1'b0, 4'd9,  2'd0, 24'h000000, 4'd5, 4'd4, 6'h20},
        '{24'h01FFFE, 2'd2, 1'b0, 4'd9,  2'd2, 24'h020000, 4'd4, 4'd3, 6'h01},
        '{24'h7FFFFF, 2'd1, 1'b0, 4'd9,  2'd2, 24'h800000, 4'd3, 4'd2, 6'h20},
        '{24'h350000, 2'd1, 1'b0, 4'd9,  2'd2, 24'h350000, 4'd1, 4'd0, 6'h00},
        '{24'h700000, 2'd3, 1'b0, 4'd8,  2'd1, 24'h700000, 4'd1, 4'd0, 6'h00},
        '{24'h700005, 2'd2, 1'b1, 4'd9,  2'd1, 24'h700005, 4'd1, 4'd0, 6'h00},
        '{24'h700001, 2'd0, 1'b0, 4'd9,  2'd0, 24'h000000, 4'd2, 4'd1, 6'h20},
        '{24'h000003, 2'd2, 1'b1, 4'd10, 2'd1, 24'h000003, 4'd1, 4'd0, 6'h00},
        '{24'h000000, 2'd1, 1'b1, 4'd10, 2'd3, 24'h000000, 4'd1, 4'd0, 6'h00}
    };

    task automatic run_vec(input vec_t v);
        logic        opf;
        string       tag;
        int          lat;
        logic [31:0] wd, exp_d;
        logic [3:0]  exp_code;
        opf = !v.wr && v.code == 4'd9 && v.sz != 2'd3;
        wd  = {v.a[7:0], ~v.a[7:0], v.a[15:8], 8'hC3};
        if (v.kind == 2'd1)      tag = (v.sz == 2'd1) ? "R3" : "R4";
        else if (v.kind == 2'd2) tag = (opf && v.nst != 0) ? "R8" : "R2";
        else if (v.kind == 2'd3) tag = "R6";
        else if (opf)            tag = "R7";
        else if (v.sz == 2'd0)   tag = "R5";
        else if (v.wr)           tag = "R9";
        else                     tag = "R1";
        @(negedge clk);
        nstb = 0; rdy_bad = 1'b0;
        chk(req_ready, "R10", "ready before request", {31'b0, req_ready}, 32'd1);
        req_valid = 1'b1; req_addr = v.a; req_size = v.sz; req_write = v.wr;
        req_code = v.code; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        exp_d = (v.kind == 2'd0 && !v.wr) ? pack_le(v.a, nbytes_of(v.sz)) : 32'd0;
        chk(lat == int'(v.lat), "R10", {tag, " latency"}, 32'(lat), 32'(v.lat));
        chk(rsp_err == (v.kind != 2'd0), "R12", {tag, " err flag"}, {31'b0, rsp_err}, {31'b0, v.kind != 2'd0});
        chk(rsp_kind == v.kind, tag, "error kind", {30'b0, rsp_kind}, {30'b0, v.kind});
        if (v.kind != 2'd0)
            chk(rsp_fault == v.fault, tag, "fault address", {8'b0, rsp_fault}, {8'b0, v.fault});
        chk(rsp_data == exp_d, tag, "response data", rsp_data, exp_d);
        chk(nstb == int'(v.nst), tag, "strobe count", 32'(nstb), 32'(v.nst));
        chk(!rdy_bad, "R10", {tag, " ready during strobe"}, {31'b0, rdy_bad}, 32'd0);
        if (v.nst != 0) begin
            chk(s_sel == v.sel, "R1", {tag, " select"}, {26'b0, s_sel}, {26'b0, v.sel});
            exp_code = opf ? 4'd9 : (v.wr ? 4'd10 : v.code);
            for (int k = 0; k < int'(v.nst); k++) begin
                chk(s_code[k] == exp_code, "R9", {tag, " strobe code"}, {28'b0, s_code[k]}, {28'b0, exp_code});
                chk(s_addr[k] == v.a + 24'(opf ? k : 0), "R7", {tag, " strobe address"},
                    {8'b0, s_addr[k]}, {8'b0, v.a + 24'(opf ? k : 0)});
                chk(s_size[k] == (opf ? 2'd0 : v.sz), "R7", {tag, " strobe size"},
                    {30'b0, s_size[k]}, {30'b0, opf ? 2'd0 : v.sz});
            end
            if (v.wr)
                chk(last_wd == wd, "R9", {tag, " write data"}, last_wd, wd);
        end
        @(negedge clk);
        chk(!rsp_valid, "R10", {tag, " response is one pulse"}, {31'b0, rsp_valid}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        nstb = 0; rdy_bad = 1'b0; last_wd = '0; s_sel = '0;
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_size = '0;
        req_write = 1'b0; req_code = '0; req_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: state held by reset
        chk(req_ready == 1'b1, "R11", "ready in reset", {31'b0, req_ready}, 32'd1);
        chk(dev_stb == 1'b0 && dev_sel == '0, "R11", "strobe in reset", {25'b0, dev_stb, dev_sel}, 32'd0);
        chk(rsp_valid == 1'b0, "R11", "response in reset", {31'b0, rsp_valid}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) run_vec(VT[i]);

        // R11: reset in the middle of a word operand fetch
        @(negedge clk);
        req_valid = 1'b1; req_addr = 24'h700000; req_size = 2'd2; req_write = 1'b0; req_code = 4'd9;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(dev_stb == 1'b1, "R11", "fetch under way before reset", {31'b0, dev_stb}, 32'd1);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(dev_stb == 1'b0 && dev_sel == '0, "R11", "strobe after mid-fetch reset", {25'b0, dev_stb, dev_sel}, 32'd0);
        chk(req_ready == 1'b1, "R11", "ready after mid-fetch reset", {31'b0, req_ready}, 32'd1);
        chk(rsp_valid == 1'b0, "R11", "no response after mid-fetch reset", {31'b0, rsp_valid}, 32'd0);
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0 && dev_stb == 1'b0, "R11", "fetch stays abandoned", {30'b0, rsp_valid, dev_stb}, 32'd0);

        // A normal request right after reset still works (R7)
        run_vec('{24'h600001, 2'd2, 1'b0, 4'd9, 2'd0, 24'h000000, 4'd5, 4'd4, 6'h10});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule